// File: doc/BRIEF.md
# Trace Buffer Fill-Level Tracker

This block keeps the fill level of a 64-line trace memory during a debug capture session. Each line is 64 bits wide. The level is counted in half-line (32-bit) steps and held in a 7-bit count. A full-line store adds two to the count. A half-line store adds one, which is how a lone 32-bit capture from a single source shows up. When the count wraps past its top value, a sticky full flag is raised. The write pointer for the trace memory is the line part of the count.

The capture alignment mode decides what happens at the wrap. In the begin-aligned mode the session ends: the block raises a one-cycle request to clear the arm bit and ignores any further stores. In the mid-aligned and end-aligned modes counting carries on. The pointer then walks over the oldest lines, and a nonzero count with the flag set means the memory holds 64 lines of which the oldest have been overwritten.

A write of one to the arm bit restarts the session from empty. Only power-on reset otherwise clears the count and the flag. A system reset disarms capture but leaves the fill level readable, so software can still see how much was captured before the reset hit. Reading entries out of the trace memory never changes the level.

Top module: `trace_fill_tracker`

## Requirements
- R1: While por_n is low, count, full, wr_ptr and arm_clr_req are all zero, and the block is unarmed, so store strobes have no effect until arm_set is pulsed.
- R2: While armed, each cycle with store_line high adds 2 to count, modulo 128. Each cycle with store_half high and store_line low adds 1. When both are high, only the 2 is added.
- R3: A store that carries count past 127 into the next value sets full. Once set, full stays set until arm_set or power-on reset.
- R4: In align_mode 2'b01 (mid) or 2'b10 (end), and also for 2'b11, stores keep being counted after the wrap. Count restarts from the wrapped value while full stays set.
- R5: In align_mode 2'b00 (begin), the store that causes the wrap makes arm_clr_req high for exactly the following cycle and disarms the block. Later stores leave count and full unchanged.
- R6: A cycle with arm_set high makes count 0 and full 0 and arms the block on the next edge. A store in that same cycle is discarded.
- R7: Holding sys_rst_n low disarms the block but leaves count and full unchanged.
- R8: rd_stb has no effect on any output.
- R9: While the block is unarmed, store_line and store_half leave count and full unchanged.
- R10: wr_ptr equals count divided by 2 (count bits 6 to 1), so it advances by one line with each full-line store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low; clears everything |
| sys_rst_n | input | 1 | System reset, asynchronous, active low; disarms only |
| arm_set | input | 1 | Strobe: a one is written to the arm bit |
| store_half | input | 1 | Strobe: a 32-bit half line was stored |
| store_line | input | 1 | Strobe: a full 64-bit line was stored |
| align_mode | input | 2 | Trigger alignment: 00 begin, 01 mid, 10 end (11 behaves as mid) |
| rd_stb | input | 1 | Trace memory read strobe (does not affect the level) |
| count | output | 7 | Fill level in half-line units |
| full | output | 1 | Sticky wrap flag |
| arm_clr_req | output | 1 | One-cycle request to clear the arm bit |
| wr_ptr | output | 6 | Line index for the next full-line store |

## Verification
The assertions take for granted that the strobes are synchronous to clk and that both resets are released away from the active edge. They expect a half-line store to reach the top odd value only by normal counting. They also allow align_mode to change at any time, since it is only sampled in the cycle of the wrap. The stimulus drives every input on the falling edge. It releases the resets on falling edges and changes align_mode only while the block is disarmed or far from the wrap. This makes sure each wrap is taken under a known mode.

// File: rtl/trace_fill_pkg.sv
package trace_fill_pkg;
  typedef enum logic [1:0] {
    ALIGN_BEGIN = 2'b00,
    ALIGN_MID   = 2'b01,
    ALIGN_END   = 2'b10
  } align_e;

  function automatic int cnt_width(input int lines);
    return $clog2(lines) + 1;
  endfunction
endpackage

// File: rtl/tfill_counter.sv
module tfill_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             clr,
  input  logic             inc_en,
  input  logic             inc_two,
  output logic [CNT_W-1:0] cnt,
  output logic             full,
  output logic             wrap
);
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] cnt_d;
  logic             full_d;
  logic             en;

  always_comb begin
    sum    = {1'b0, cnt} + (inc_two ? (CNT_W+1)'(2) : (CNT_W+1)'(1));
    wrap   = inc_en && sum[CNT_W];
    en     = clr || inc_en;
    cnt_d  = cnt;
    full_d = full;
    if (clr) begin
      cnt_d  = '0;
      full_d = 1'b0;
    end else if (inc_en) begin
      cnt_d  = sum[CNT_W-1:0];
      full_d = full || sum[CNT_W];
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt  <= '0;
      full <= 1'b0;
    end else if (en) begin
      cnt  <= cnt_d;
      full <= full_d;
    end
  end
endmodule

// File: rtl/tfill_arm_ctl.sv
module tfill_arm_ctl (
  input  logic clk,
  input  logic por_n,
  input  logic sys_rst_n,
  input  logic arm_set,
  input  logic stop_req,
  output logic armed,
  output logic arm_clr_req
);
  logic armed_d;
  logic clr_req_d;

  always_comb begin
    armed_d   = armed;
    clr_req_d = 1'b0;
    if (arm_set) begin
      armed_d = 1'b1;
    end else if (stop_req) begin
      armed_d   = 1'b0;
      clr_req_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n or negedge sys_rst_n) begin
    if (!por_n || !sys_rst_n) begin
      armed       <= 1'b0;
      arm_clr_req <= 1'b0;
    end else begin
      armed       <= armed_d;
      arm_clr_req <= clr_req_d;
    end
  end
endmodule

// File: rtl/trace_fill_tracker.sv
module trace_fill_tracker
  import trace_fill_pkg::*;
#(
  parameter int LINES = 64,
  localparam int CNT_W = cnt_width(LINES),
  localparam int PTR_W = CNT_W - 1
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             sys_rst_n,
  input  logic             arm_set,
  input  logic             store_half,
  input  logic             store_line,
  input  logic [1:0]       align_mode,
  input  logic             rd_stb,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             arm_clr_req,
  output logic [PTR_W-1:0] wr_ptr
);
  logic armed;
  logic inc_en;
  logic wrap;
  logic stop_req;
  logic unused_rd;

  // Reads of the trace memory never touch the fill level.
  assign unused_rd = rd_stb;

  assign inc_en   = armed && !arm_set && (store_line || store_half);
  assign stop_req = wrap && (align_mode == ALIGN_BEGIN);

  tfill_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .por_n   (por_n),
    .clr     (arm_set),
    .inc_en  (inc_en),
    .inc_two (store_line),
    .cnt     (count),
    .full    (full),
    .wrap    (wrap)
  );

  tfill_arm_ctl u_arm (
    .clk         (clk),
    .por_n       (por_n),
    .sys_rst_n   (sys_rst_n),
    .arm_set     (arm_set),
    .stop_req    (stop_req),
    .armed       (armed),
    .arm_clr_req (arm_clr_req)
  );

  assign wr_ptr = count[CNT_W-1:1];
endmodule

// File: rtl/tfill_checker.sv
module tfill_checker #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             por_n,
  input logic             sys_rst_n,
  input logic             arm_set,
  input logic             store_half,
  input logic             store_line,
  input logic             armed,
  input logic [CNT_W-1:0] count,
  input logic             full,
  input logic             arm_clr_req
);
  localparam logic [CNT_W-1:0] TOP_EVEN = {{(CNT_W-1){1'b1}}, 1'b0};

  p_line_add_two_r2: assert property (@(posedge clk) disable iff (!por_n)
    (armed && sys_rst_n && !arm_set && store_line) |=> (count == $past(count) + CNT_W'(2)));

  p_half_add_one_r2: assert property (@(posedge clk) disable iff (!por_n)
    (armed && sys_rst_n && !arm_set && store_half && !store_line) |=> (count == $past(count) + CNT_W'(1)));

  p_wrap_sets_full_r3: assert property (@(posedge clk) disable iff (!por_n)
    (armed && sys_rst_n && !arm_set && store_line && count == TOP_EVEN) |=> (full && count == '0));

  p_full_sticky_r3: assert property (@(posedge clk) disable iff (!por_n)
    (full && !arm_set) |=> full);

  p_clr_req_after_wrap_r5: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    arm_clr_req |-> (full && !armed));

  p_clr_req_one_cycle_r5: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    (arm_clr_req && !arm_set) |=> !arm_clr_req);

  p_arm_clears_r6: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    arm_set |=> (count == '0 && !full && armed));

  p_sysrst_keeps_r7: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst_n && !arm_set) |=> ($stable(count) && $stable(full)));

  p_unarmed_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
    (!armed && !arm_set) |=> ($stable(count) && $stable(full)));
endmodule

bind trace_fill_tracker tfill_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .sys_rst_n   (sys_rst_n),
  .arm_set     (arm_set),
  .store_half  (store_half),
  .store_line  (store_line),
  .armed       (armed),
  .count       (count),
  .full        (full),
  .arm_clr_req (arm_clr_req)
);

// File: tb/tb_trace_fill_tracker.sv
module tb_trace_fill_tracker;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       por_n, sys_rst_n, arm_set, store_half, store_line, rd_stb;
  logic [1:0] align_mode;
  logic [6:0] count;
  logic       full, arm_clr_req;
  logic [5:0] wr_ptr;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_fill_tracker dut (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .arm_set(arm_set),
    .store_half(store_half), .store_line(store_line), .align_mode(align_mode),
    .rd_stb(rd_stb), .count(count), .full(full), .arm_clr_req(arm_clr_req),
    .wr_ptr(wr_ptr)
  );

  // arm, half, line, rd, mode, expected count, expected full
  typedef struct packed {
    logic       arm;
    logic       half;
    logic       line;
    logic       rd;
    logic [1:0] mode;
    logic [6:0] ecnt;
    logic       efull;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 7'd0, 1'b0},  // idle
    '{1'b0, 1'b0, 1'b1, 1'b0, 2'b10, 7'd0, 1'b0},  // R9 line unarmed
    '{1'b0, 1'b1, 1'b0, 1'b0, 2'b10, 7'd0, 1'b0},  // R9 half unarmed
    '{1'b1, 1'b0, 1'b0, 1'b0, 2'b10, 7'd0, 1'b0},  // R6 arm
    '{1'b0, 1'b0, 1'b1, 1'b0, 2'b10, 7'd2, 1'b0},  // R2 line
    '{1'b0, 1'b1, 1'b0, 1'b0, 2'b10, 7'd3, 1'b0},  // R2 half
    '{1'b0, 1'b1, 1'b1, 1'b0, 2'b10, 7'd5, 1'b0},  // R2 both: line wins
    '{1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 7'd5, 1'b0},  // R8 read
    '{1'b0, 1'b0, 1'b1, 1'b1, 2'b01, 7'd7, 1'b0},  // R2/R8 line with read
    '{1'b1, 1'b0, 1'b1, 1'b0, 2'b10, 7'd0, 1'b0},  // R6 arm discards store
    '{1'b0, 1'b1, 1'b0, 1'b0, 2'b10, 7'd1, 1'b0},  // R2 half after arm
    '{1'b0, 1'b0, 1'b1, 1'b0, 2'b10, 7'd3, 1'b0}   // R2 line
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    arm_set = 0; store_half = 0; store_line = 0; rd_stb = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    por_n = 0; sys_rst_n = 1; align_mode = 2'b10;
    idle();
    repeat (3) step();
    chk("R1 count", count, 0);
    chk("R1 full", full, 0);
    chk("R1 wr_ptr", wr_ptr, 0);
    chk("R1 arm_clr_req", arm_clr_req, 0);
    por_n = 1;
    step();

    for (int i = 0; i < NV; i++) begin
      arm_set = VEC[i].arm; store_half = VEC[i].half;
      store_line = VEC[i].line; rd_stb = VEC[i].rd; align_mode = VEC[i].mode;
      step();
      chk($sformatf("R2 vector %0d count", i), count, VEC[i].ecnt);
      chk($sformatf("R3 vector %0d full", i), full, VEC[i].efull);
    end
    idle();
    chk("R10 wr_ptr at count 3", wr_ptr, 1);

    // End-aligned wrap: continue counting and overwrite
    align_mode = 2'b10;
    arm_set = 1; step(); idle();
    store_line = 1;
    repeat (63) step();
    chk("R2 count at 63 lines", count, 126);
    chk("R3 full before wrap", full, 0);
    chk("R10 wr_ptr at 63 lines", wr_ptr, 63);
    step();
    chk("R3 count at wrap", count, 0);
    chk("R3 full at wrap", full, 1);
    chk("R4 no arm clear in end mode", arm_clr_req, 0);
    step();
    idle();
    chk("R4 count continues", count, 2);
    chk("R4 full kept", full, 1);
    chk("R10 wr_ptr overwrites oldest", wr_ptr, 1);

    // System reset keeps level, disarms
    sys_rst_n = 0; step();
    chk("R7 count kept", count, 2);
    chk("R7 full kept", full, 1);
    sys_rst_n = 1; store_line = 1; step(); idle();
    chk("R7 disarmed after sys reset", count, 2);

    // Begin-aligned wrap ends the session
    align_mode = 2'b00;
    arm_set = 1; step(); idle();
    chk("R6 arm clears full", full, 0);
    store_line = 1;
    repeat (64) step();
    chk("R5 count at wrap", count, 0);
    chk("R5 full at wrap", full, 1);
    chk("R5 arm clear request", arm_clr_req, 1);
    step();
    chk("R5 request one cycle", arm_clr_req, 0);
    chk("R5 store ignored after end", count, 0);
    store_line = 0; store_half = 1; step(); idle();
    chk("R5 half ignored after end", count, 0);

    // Half-line wrap and sticky flag, mid mode
    align_mode = 2'b01;
    arm_set = 1; step(); idle();
    store_line = 1; repeat (63) step(); idle();
    store_half = 1; step();
    chk("R2 half to top", count, 127);
    step();
    chk("R3 half wrap count", count, 0);
    chk("R3 half wrap full", full, 1);
    step(); idle();
    chk("R3 full sticky", full, 1);
    chk("R4 count after half wrap", count, 1);

    // Power-on reset mid-session
    por_n = 0; step();
    chk("R1 por count", count, 0);
    chk("R1 por full", full, 0);
    por_n = 1; store_line = 1; step(); idle();
    chk("R1 unarmed after por", count, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule